// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for a larger chip. Its time base has two stages. The first is an 8-bit programmable prescaler, and its field holds the divisor minus one. The second is a fixed post-divider that can be set to 16, 32, 64 or 128. Each divided tick decrements a 16-bit live count. When the count is zero and a tick arrives, the counter reloads from a separate reload register and keeps running. This event is the expiry. Depending on two independent enables, an expiry raises a one-cycle interrupt pulse, a long system-reset pulse, or both.

Software accesses the block over a simple register bus that has address, write enable, write data and combinational read data. To start the timer, software writes the same value to the reload register and to the live count, then sets the run enable. To keep the system alive, software rewrites the live count before it runs out. To stop the timer, software clears the run enable and the reset enable.

Top module: `wdog_timer`

## Requirements
- R1: Out of reset, control reads 0x8000 (prescale field 0x80, every other field 0), the reload register and the live count both read 0x8000, and both pulse outputs are low.
- R2: The control register is at 0x0, the reload register at 0x4 and the live count at 0x8. Any other address reads 0. Writing the reload register leaves the live count unchanged.
- R3: In control, bit 0 is run enable, bit 1 is interrupt enable and bit 2 is reset enable. Bits 4:3 select the post-divider as 16 << sel, so sel=3 gives 128. Bits 15:8 hold the prescale minus one. Unused bits read 0. A tick occurs once every (prescale+1)·(16<<sel) clock cycles.
- R4: While run enable is set, each tick lowers a non-zero live count by one.
- R5: A tick that finds the live count at zero reloads it from the reload register and counts as one expiry.
- R6: A write to the live count sets it to the written value on the next edge. The write takes precedence over a tick in the same cycle, and the countdown restarts from that value (keep-alive).
- R7: The interrupt output is high for exactly the cycle after an expiry, and only when interrupt enable is set.
- R8: Starting the cycle after an expiry with reset enable set, the reset output stays high for 128 cycles.
- R9: Any write to control restarts the tick phase from zero and suppresses a tick in that cycle. With run enable clear, the live count holds and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt on expiry |
| rst_pulse | output | 1 | Stretched system-reset request |

## Verification
The assertions assume that a bus write carries a single, well-formed access per cycle. They also assume that control writes use only the defined bits, so that the tick phase and the enables change only at control writes. The stimulus writes one register per cycle through a task that holds each access for exactly one edge. The stimulus also places live-count writes at several phases of the tick period, so that some of them coincide with a tick. A behavioural model in the bench counts cycles into the tick period instead of tracking the two divider stages, and it is compared with the outputs on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PSC_W  = 8;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int POST_W = 8;

  localparam logic [3:0] ADDR_CTRL   = 4'h0;
  localparam logic [3:0] ADDR_RELOAD = 4'h4;
  localparam logic [3:0] ADDR_COUNT  = 4'h8;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [SEL_W-1:0] sel;
    logic             rst_en;
    logic             irq_en;
    logic             run;
  } wdog_ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(wdog_ctrl_t c);
    return {c.psc, 3'b000, c.sel, c.rst_en, c.irq_en, c.run};
  endfunction

  function automatic wdog_ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    wdog_ctrl_t c;
    c.psc    = w[15:8];
    c.sel    = w[4:3];
    c.rst_en = w[2];
    c.irq_en = w[1];
    c.run    = w[0];
    return c;
  endfunction

  // Last value of the post-divider phase: (16 << sel) - 1
  function automatic logic [POST_W-1:0] post_last(logic [SEL_W-1:0] sel);
    logic [POST_W:0] span;
    span = (POST_W+1)'(16) << sel;
    return POST_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic [PSC_W-1:0]  psc,
  input  logic [POST_W-1:0] post_lim,
  output logic              tick
);
  logic [PSC_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic              pre_hit;

  assign pre_hit = run && !clear && (pre_cnt == psc);
  assign tick    = pre_hit && (post_cnt == post_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (clear || !run) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt  <= '0;
      post_cnt <= (post_cnt == post_lim) ? '0 : post_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_down_count.sv
module wdog_down_count
  import wdog_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = run && tick && !load && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= INIT;
    else if (load)           count <= load_val;
    else if (run && tick)    count <= (count == '0) ? reload_val : count - 1'b1;
  end
endmodule

// File: rtl/wdog_reset_stretch.sv
module wdog_reset_stretch #(
  parameter int LEN = 128,
  localparam int LW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  logic [LW-1:0] remain;

  assign active = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       remain <= '0;
    else if (trig)    remain <= LW'(LEN);
    else if (active)  remain <= remain - 1'b1;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int               RST_LEN  = 128,
  parameter logic [CNT_W-1:0] CNT_INIT = 16'h8000,
  parameter logic [PSC_W-1:0] PSC_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              rst_pulse
);
  wdog_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_w;
  logic             wr_ctrl, wr_reload, wr_count;
  logic             tick_w, expire_w;
  logic             irq_q;

  assign wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_reload = bus_we && (bus_addr == ADDR_RELOAD);
  assign wr_count  = bus_we && (bus_addr == ADDR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '{psc: PSC_INIT, sel: '0, rst_en: 1'b0, irq_en: 1'b0, run: 1'b0};
      reload_q <= CNT_INIT;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_unpack(bus_wdata);
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      irq_q <= expire_w && ctrl_q.irq_en;
    end
  end

  wdog_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .clear(wr_ctrl),
    .psc(ctrl_q.psc), .post_lim(post_last(ctrl_q.sel)), .tick(tick_w)
  );

  wdog_down_count #(.INIT(CNT_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick_w),
    .load(wr_count), .load_val(bus_wdata[CNT_W-1:0]), .reload_val(reload_q),
    .count(count_w), .expire(expire_w)
  );

  wdog_reset_stretch #(.LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(expire_w && ctrl_q.rst_en), .active(rst_pulse)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:   bus_rdata = ctrl_pack(ctrl_q);
      ADDR_RELOAD: bus_rdata = reload_q;
      ADDR_COUNT:  bus_rdata = count_w;
      default:     bus_rdata = '0;
    endcase
  end

  assign irq_pulse = irq_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             irq_en,
  input logic             rst_en,
  input logic             tick,
  input logic             expire,
  input logic             wr_ctrl,
  input logic             wr_count,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             rstp
);
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_count && count != '0) |=> (count == $past(count) - 1'b1));

  p_expiry_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (count == '0 && run && tick));

  p_no_tick_on_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |-> !tick);

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count) |=> $stable(count));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire && irq_en));

  p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstp) |-> $past(expire && rst_en));
endmodule

bind wdog_timer wdog_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .irq_en(ctrl_q.irq_en),
  .rst_en(ctrl_q.rst_en), .tick(tick_w), .expire(expire_w),
  .wr_ctrl(wr_ctrl), .wr_count(wr_count), .count(count_w),
  .irq(irq_pulse), .rstp(rst_pulse)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq_pulse, rst_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int irq_seen = 0, irq_model_total = 0, rst_seen = 0;

  // reference model state
  int m_ctrl, m_reload, m_count, m_phase, m_rc;
  bit m_irq;

  always #2.5 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .rst_pulse(rst_pulse)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // model: counts cycles into the tick period
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ctrl = 'h8000; m_reload = 'h8000; m_count = 'h8000;
      m_phase = 0; m_rc = 0; m_irq = 0;
    end else begin
      bit tk, ex, wc, wr, wn;
      int period;
      tk = 0; ex = 0;
      wc = bus_we && bus_addr == 4'h0;
      wr = bus_we && bus_addr == 4'h4;
      wn = bus_we && bus_addr == 4'h8;
      period = (((m_ctrl >> 8) & 'hFF) + 1) * (16 << ((m_ctrl >> 3) & 3));
      if (wc || !m_ctrl[0]) m_phase = 0;
      else if (m_phase == period - 1) begin m_phase = 0; tk = 1; end
      else m_phase++;
      if (wn) m_count = bus_wdata;
      else if (m_ctrl[0] && tk) begin
        if (m_count == 0) begin ex = 1; m_count = m_reload; end
        else m_count--;
      end
      m_irq = ex && m_ctrl[1];
      if (m_irq) irq_model_total++;
      if (ex && m_ctrl[2]) m_rc = 128;
      else if (m_rc > 0) m_rc--;
      if (wc) m_ctrl = bus_wdata & 'hFF1F;
      if (wr) m_reload = bus_wdata;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    int exp_rd;
    string tag;
    case (bus_addr)
      4'h0: begin exp_rd = m_ctrl;   tag = "R3 ctrl read";   end
      4'h4: begin exp_rd = m_reload; tag = "R2 reload read"; end
      4'h8: begin exp_rd = m_count;  tag = "R4 count read";  end
      default: begin exp_rd = 0;     tag = "R2 unmapped read"; end
    endcase
    check(tag, bus_rdata, exp_rd);
    check("R7 irq", irq_pulse, m_irq);
    check("R8 rst", rst_pulse, m_rc != 0);
    if (irq_pulse) irq_seen++;
    if (rst_pulse) rst_seen++;
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [3:0] a, int exp);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int snap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd_check("R1 ctrl reset", 4'h0, 'h8000);
    rd_check("R1 reload reset", 4'h4, 'h8000);
    rd_check("R1 count reset", 4'h8, 'h8000);
    rd_check("R2 unmapped", 4'hC, 0);
    check("R1 irq low", irq_pulse, 0);
    check("R1 rst low", rst_pulse, 0);
    // R2 reload write leaves count alone
    wr(4'h4, 16'd5);
    rd_check("R2 count untouched", 4'h8, 'h8000);
    // R3 unused ctrl bits read zero
    wr(4'h0, 16'h00E0);
    rd_check("R3 unused bits", 4'h0, 0);
    // R4 R5 R7: psc=1, sel=0 -> 32-cycle tick, irq only
    wr(4'h8, 16'd3);
    wr(4'h0, 16'h0103);
    idle(500);
    check("R7 irq count", irq_seen, irq_model_total);
    check("R7 irq occurred", irq_seen > 0, 1);
    // R6 keep-alive at shifting phases: no expiry
    snap = irq_seen;
    for (int i = 0; i < 12; i++) begin
      wr(4'h8, 16'd2);
      idle(40 + i);
    end
    check("R6 keepalive no irq", irq_seen, snap);
    // R8: sel=3, psc=0 -> 128-cycle tick, reset only
    wr(4'h0, 16'h0018 | 16'h0005);
    wr(4'h8, 16'd1);
    snap = rst_seen;
    idle(600);
    check("R8 reset length", rst_seen - snap, 128);
    // R9 stop: count holds
    wr(4'h0, 16'h0000);
    rd_check("R9 stopped read", 4'h8, m_count);
    snap = m_count;
    idle(300);
    rd_check("R9 count held", 4'h8, snap);
    // R3 sel=1 psc=2 -> 96-cycle tick, both outputs, ctrl rewrites restart phase
    wr(4'h4, 16'd1);
    wr(4'h8, 16'd0);
    wr(4'h0, 16'h020B | 16'h0004);
    idle(150);
    wr(4'h0, 16'h020F);
    idle(700);
    check("R5 irq vs model", irq_seen, irq_model_total);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule